// File: doc/BRIEF.md
# USB Host Controller Functional State Register

This block keeps the functional state of a USB host controller and its two remote-wakeup configuration bits. It sits behind a host-side register port, so software reads and writes the state field directly. The hardware can change that state on its own only while the bus is suspended: resume signalling seen on a downstream port moves it to the resume state. The block also turns the state into three control outputs. The first is a start-of-frame enable that opens only after a settling delay counted in millisecond ticks. The second is a downstream reset request held for a fixed time after a hardware reset. The third is a remote-wakeup indication to the host system.

There are two reset inputs, and they do different things. The hardware reset clears everything and starts the downstream reset request. The software reset returns the state to reset and clears the wakeup enable, but it keeps the wakeup-connected bit that firmware set up. SOF packet generation, root hub port logic, the bus interface and interrupt gathering belong to neighbouring blocks.

Top module: `hc_fstate_reg`

## Requirements
- R1: While the hardware reset is held and just after it, the state output is 00, the read word is 0 and the SOF enable is 0.
- R2: A register write loads the state from bits 7:6 of the write word, with the encoding 00 reset, 01 resume, 10 operational, 11 suspend. The new state shows on the state output and in read bits 7:6 in the cycle after the write.
- R3: Only bit 10 (wakeup enable), bit 9 (wakeup connected) and bits 7:6 (state) hold data. Every other read bit is 0, and writing ones to those other bits has no effect.
- R4: After the state enters operational from any other state, the SOF enable rises on the SOF_TICKS-th millisecond tick that follows the entry. A tick in the same cycle as the entering write is not counted. Writing operational while already operational does not restart the count.
- R5: The SOF enable is 0 whenever the state is not operational. Leaving operational cancels a pending count, and a later entry counts the full delay again.
- R6: In suspend, a resume event moves the state to resume (01) in the next cycle. In the other three states a resume event has no effect. A register write in the same cycle takes priority over the event.
- R7: A software reset sets the state to 00 and clears the wakeup enable, and leaves the wakeup-connected bit unchanged. A register write in the same cycle is ignored.
- R8: A hardware reset clears both the wakeup enable and the wakeup-connected bits.
- R9: The downstream reset request is 1 from the hardware reset until RST_TICKS millisecond ticks have been counted after the reset is released, and 0 afterwards. A software reset does not raise it.
- R10: The remote-wakeup output equals the wakeup enable bit ANDed with the resume-detected status input, with no delay. The output is not registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| rd_data | output | 32 | Register read word |
| resume_evt | input | 1 | Resume signalling detected downstream |
| resume_sts | input | 1 | Resume-detected status flag |
| fstate | output | 2 | Current functional state |
| sof_en | output | 1 | Start-of-frame generation enable |
| port_rst_req | output | 1 | Downstream reset request |
| rwake_out | output | 1 | Remote-wakeup signal to host system |

## Verification
Writes, resume events and software resets take effect at the clock edge that samples them. State and read data are therefore due one cycle later, and the bench drives on the falling edge and compares on the next falling edge. The SOF enable and the reset request change at the edge that samples the deciding tick, so the bench applies the delay minus one ticks, checks that the output has not yet changed, then applies one more tick and checks again. The remote-wakeup output is combinational, so it is compared in the same half cycle as the status input that drives it.

// File: rtl/hc_fs_pkg.sv
package hc_fs_pkg;
   typedef enum logic [1:0] {
      HFS_RESET   = 2'b00,
      HFS_RESUME  = 2'b01,
      HFS_OPER    = 2'b10,
      HFS_SUSPEND = 2'b11
   } hfs_e;

   localparam int REG_W     = 32;
   localparam int ST_LSB    = 6;
   localparam int ST_MSB    = 7;
   localparam int RWC_BIT   = 9;
   localparam int RWE_BIT   = 10;
   localparam logic [REG_W-1:0] LIVE_MASK =
      (32'h1 << RWE_BIT) | (32'h1 << RWC_BIT) | (32'h3 << ST_LSB);
endpackage

// File: rtl/hc_tick_timer.sv
module hc_tick_timer #(
   parameter int TICKS       = 1,
   parameter bit RESET_ARMED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clear,
   input  logic tick,
   output logic expired
);
   localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
   localparam logic [CW-1:0] LOAD_V = CW'(TICKS);

   generate
      if (TICKS < 1) begin : g_bad
         $error("hc_tick_timer: TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RESET_ARMED ? LOAD_V : '0;
         exp_q <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (load) begin
         cnt_q <= LOAD_V;
         exp_q <= 1'b0;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CW'(1)) exp_q <= 1'b1;
      end
   end

   assign expired = exp_q;
endmodule

// File: rtl/hc_fs_ctrl.sv
module hc_fs_ctrl
   import hc_fs_pkg::*;
(
   input  logic             clk,
   input  logic             hw_rst_n,
   input  logic             sw_rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             resume_evt,
   output hfs_e             st_q,
   output hfs_e             st_d,
   output logic             rwe_q,
   output logic             rwc_q
);
   logic rwe_d, rwc_d;

   always_comb begin
      st_d  = st_q;
      rwe_d = rwe_q;
      rwc_d = rwc_q;
      if (sw_rst) begin
         st_d  = HFS_RESET;
         rwe_d = 1'b0;
      end else if (wr_en) begin
         st_d  = hfs_e'(wr_data[ST_MSB:ST_LSB]);
         rwe_d = wr_data[RWE_BIT];
         rwc_d = wr_data[RWC_BIT];
      end else if ((st_q == HFS_SUSPEND) && resume_evt) begin
         st_d  = HFS_RESUME;
      end
   end

   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n) begin
         st_q  <= HFS_RESET;
         rwe_q <= 1'b0;
         rwc_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         rwe_q <= rwe_d;
         rwc_q <= rwc_d;
      end
   end
endmodule

// File: rtl/hc_fstate_reg.sv
module hc_fstate_reg
   import hc_fs_pkg::*;
#(
   parameter int SOF_TICKS = 1,
   parameter int RST_TICKS = 10
) (
   input  logic        clk,
   input  logic        hw_rst_n,
   input  logic        sw_rst,
   input  logic        ms_tick,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   input  logic        resume_evt,
   input  logic        resume_sts,
   output logic [1:0]  fstate,
   output logic        sof_en,
   output logic        port_rst_req,
   output logic        rwake_out
);
   hfs_e st_q, st_d;
   logic rwe_q, rwc_q;
   logic sof_load, sof_clear, pr_done;

   hc_fs_ctrl u_ctrl (
      .clk        (clk),
      .hw_rst_n   (hw_rst_n),
      .sw_rst     (sw_rst),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .resume_evt (resume_evt),
      .st_q       (st_q),
      .st_d       (st_d),
      .rwe_q      (rwe_q),
      .rwc_q      (rwc_q)
   );

   assign sof_clear = (st_d != HFS_OPER);
   assign sof_load  = (st_d == HFS_OPER) && (st_q != HFS_OPER);

   hc_tick_timer #(.TICKS(SOF_TICKS), .RESET_ARMED(1'b0)) u_sof_tmr (
      .clk     (clk),
      .rst_n   (hw_rst_n),
      .load    (sof_load),
      .clear   (sof_clear),
      .tick    (ms_tick),
      .expired (sof_en)
   );

   hc_tick_timer #(.TICKS(RST_TICKS), .RESET_ARMED(1'b1)) u_prst_tmr (
      .clk     (clk),
      .rst_n   (hw_rst_n),
      .load    (1'b0),
      .clear   (1'b0),
      .tick    (ms_tick),
      .expired (pr_done)
   );

   assign port_rst_req = ~pr_done;
   assign fstate       = st_q;
   assign rwake_out    = rwe_q & resume_sts;

   always_comb begin
      rd_data                 = '0;
      rd_data[ST_MSB:ST_LSB]  = st_q;
      rd_data[RWC_BIT]        = rwc_q;
      rd_data[RWE_BIT]        = rwe_q;
   end
endmodule

// File: rtl/hc_fstate_chk.sv
module hc_fstate_chk (
   input logic        clk,
   input logic        hw_rst_n,
   input logic        sw_rst,
   input logic        ms_tick,
   input logic        wr_en,
   input logic [31:0] rd_data,
   input logic        resume_evt,
   input logic        resume_sts,
   input logic [1:0]  fstate,
   input logic        sof_en,
   input logic        port_rst_req,
   input logic        rwake_out
);
   // R2
   state_hold_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (!wr_en && !sw_rst && !(fstate == 2'b11 && resume_evt)) |=> $stable(fstate));
   // R3
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (rd_data & ~32'h0000_06C0) == 32'h0);
   // R4
   sof_late_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (fstate != 2'b10) |=> !sof_en);
   // R5
   sof_oper_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      sof_en |-> (fstate == 2'b10));
   // R6
   hw_resume_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (fstate == 2'b11 && resume_evt && !wr_en && !sw_rst) |=> (fstate == 2'b01));
   // R7
   sw_rst_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      sw_rst |=> (fstate == 2'b00 && !rd_data[10] && rd_data[9] == $past(rd_data[9])));
   // R9
   prst_no_rise_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      !$rose(port_rst_req));
   // R9
   prst_fall_tick_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      $fell(port_rst_req) |-> $past(ms_tick));
   // R10
   rwake_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      rwake_out |-> (rd_data[10] && resume_sts));
endmodule

bind hc_fstate_reg hc_fstate_chk u_chk (
   .clk          (clk),
   .hw_rst_n     (hw_rst_n),
   .sw_rst       (sw_rst),
   .ms_tick      (ms_tick),
   .wr_en        (wr_en),
   .rd_data      (rd_data),
   .resume_evt   (resume_evt),
   .resume_sts   (resume_sts),
   .fstate       (fstate),
   .sof_en       (sof_en),
   .port_rst_req (port_rst_req),
   .rwake_out    (rwake_out)
);

// File: tb/sim_hc_fstate_reg.sv
module sim_hc_fstate_reg;
   localparam int CLK_PER = 10;
   localparam int SOF_T   = 3;
   localparam int RST_T   = 4;

   logic        clk = 1'b0;
   logic        hw_rst_n = 1'b0;
   logic        sw_rst = 1'b0, ms_tick = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        resume_evt = 1'b0, resume_sts = 1'b0;
   logic [31:0] rd_data;
   logic [1:0]  fstate;
   logic        sof_en, port_rst_req, rwake_out;
   int          nvec = 0, nbad = 0;

   always #(CLK_PER/2) clk = ~clk;

   hc_fstate_reg #(.SOF_TICKS(SOF_T), .RST_TICKS(RST_T)) u0 (
      .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .ms_tick(ms_tick),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .resume_evt(resume_evt), .resume_sts(resume_sts), .fstate(fstate),
      .sof_en(sof_en), .port_rst_req(port_rst_req), .rwake_out(rwake_out)
   );

   function automatic logic [31:0] rdv(input int rwe, input int rwc, input int st);
      return 32'((rwe << 10) | (rwc << 9) | (st << 6));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ms_tick = 1'b1;
         @(negedge clk); ms_tick = 1'b0;
      end
   endtask

   task automatic evt;
      @(negedge clk); resume_evt = 1'b1;
      @(negedge clk); resume_evt = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 state in reset", 32'(fstate), 0);
      chk("R1 read in reset", rd_data, 0);
      chk("R1 sof in reset", 32'(sof_en), 0);
      chk("R9 port reset in reset", 32'(port_rst_req), 1);
      hw_rst_n = 1'b1;
      @(negedge clk);
      chk("R1 read after release", rd_data, 0);
      ticks(RST_T - 1);
      chk("R9 port reset held", 32'(port_rst_req), 1);
      ticks(1);
      chk("R9 port reset dropped", 32'(port_rst_req), 0);

      // R3: all ones written, only live bits stick
      wr(32'hFFFF_FFFF);
      chk("R3 reserved masked", rd_data, rdv(1, 1, 3));
      wr(32'hFFFF_F93F);
      chk("R3 reserved ignored", rd_data, 32'h0);

      // R2, R4, R5: every from/to pair
      for (int f = 0; f < 4; f++) begin
         for (int t = 0; t < 4; t++) begin
            wr(32'h0);
            wr(rdv(0, 0, f));
            if (f == 2) begin
               ticks(SOF_T);
               chk("R4 sof after delay", 32'(sof_en), 1);
            end
            wr(rdv(0, 0, t));
            chk("R2 state loaded", 32'(fstate), 32'(t));
            chk("R2 read state", rd_data, rdv(0, 0, t));
            if (f == 2 && t == 2) begin
               chk("R4 no restart in oper", 32'(sof_en), 1);
            end else begin
               chk("R5 sof low after write", 32'(sof_en), 0);
               if (t == 2) begin
                  ticks(SOF_T - 1);
                  chk("R4 sof not early", 32'(sof_en), 0);
                  ticks(1);
                  chk("R4 sof on time", 32'(sof_en), 1);
               end
            end
         end
      end

      // R5: cancel and restart
      wr(32'h0);
      wr(rdv(0, 0, 2));
      ticks(SOF_T - 1);
      wr(rdv(0, 0, 3));
      ticks(SOF_T);
      chk("R5 sof cancelled", 32'(sof_en), 0);
      wr(rdv(0, 0, 2));
      ticks(SOF_T - 1);
      chk("R5 full recount", 32'(sof_en), 0);
      ticks(1);
      chk("R5 sof after recount", 32'(sof_en), 1);

      // R6: resume event per state
      for (int s = 0; s < 4; s++) begin
         wr(rdv(0, 0, s));
         evt();
         chk("R6 resume event", 32'(fstate), (s == 3) ? 1 : s);
      end
      wr(rdv(0, 0, 3));
      @(negedge clk); resume_evt = 1'b1; wr_en = 1'b1; wr_data = rdv(0, 0, 2);
      @(negedge clk); resume_evt = 1'b0; wr_en = 1'b0;
      chk("R6 write beats event", 32'(fstate), 2);

      // R7: software reset
      wr(rdv(1, 1, 3));
      @(negedge clk); sw_rst = 1'b1;
      @(negedge clk); sw_rst = 1'b0;
      chk("R7 soft reset keeps rwc", rd_data, rdv(0, 1, 0));
      chk("R9 no port reset on soft", 32'(port_rst_req), 0);
      wr(rdv(1, 0, 3));
      @(negedge clk); sw_rst = 1'b1; wr_en = 1'b1; wr_data = rdv(1, 1, 2);
      @(negedge clk); sw_rst = 1'b0; wr_en = 1'b0;
      chk("R7 write ignored", rd_data, rdv(0, 0, 0));

      // R10: wakeup combinations
      for (int e = 0; e < 2; e++) begin
         for (int st = 0; st < 2; st++) begin
            wr(rdv(e, 0, 0));
            resume_sts = st[0];
            #1;
            chk("R10 remote wake", 32'(rwake_out), 32'(e & st));
            resume_sts = 1'b0;
         end
      end

      // R8: hardware reset clears config
      wr(rdv(1, 1, 2));
      @(negedge clk); hw_rst_n = 1'b0;
      @(negedge clk); hw_rst_n = 1'b1;
      @(negedge clk);
      chk("R8 hard reset clears", rd_data, 0);
      chk("R9 port reset again", 32'(port_rst_req), 1);

      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule